// File: doc/BRIEF.md
# Two-wire Digital Potentiometer Command Controller

This block is the digital side of a two-wire-bus resistor controller. It watches SCL and SDA as a bus target, accepts 16-bit command words, and keeps the state that sets a resistor: the live wiper code, a persistent saved copy of that code, a shutdown flag, and a selector that chooses which byte a later read returns. The persistent store is modelled as a small register array. Each store takes a set number of clock cycles to complete.

A write is one address byte with the read/write bit low, followed by a high byte and a low byte. The command code sits in the low three bits of the high byte, and the operand is the whole low byte. A read is one address byte with the read/write bit high. The target then returns the one byte chosen by the most recent select command. SCL and SDA pass through two-flop synchronisers on the system clock. The system clock must therefore run many times faster than SCL; 100 MHz covers a 400 kHz bus with a wide margin.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The target acknowledges an address byte only when bits 7..1 equal the parameter DEV_ADDR (default 0101111); any other address is not acknowledged, and the words that follow change nothing.
- R2: In a write to a matching address, the target pulls SDA low during the acknowledge bit after the address byte, after the high byte and after the low byte.
- R3: Command code 2 (bits 2..0 of the high byte) loads low-byte bits WIPER_W-1..0 into the wiper, so data 0x80 gives wiper 0. The wiper changes only after the acknowledge of the low byte.
- R4: A stop or a start that arrives before the low byte has been acknowledged discards the partial word, and no state changes.
- R5: Command code 3 sets the shutdown output to bit 0 of the low byte and ignores low-byte bits 7..1.
- R6: Command code 1 copies the wiper into saved location 0 once the store delay has elapsed. Command code 4 reloads the wiper from saved location 0.
- R7: After command code 5, a read returns the wiper code with zeros in the bits above the wiper width.
- R8: After command code 6, a read returns saved location (low-byte bits 1..0): 0 is the saved wiper and 1 is the tolerance byte TOL_BYTE.
- R9: After reset, the wiper equals the saved wiper (reset value INIT_WIPER), shutdown is 0, and SDA is not pulled while the bus is idle.
- R10: Command codes 0 and 7 change neither the wiper nor shutdown.
- R11: A store that arrives while an earlier store is still in progress is acknowledged and queued. It runs when the first store finishes and takes the wiper value of that moment. Until a store finishes, location 0 keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | WIPER_W (7) | Live wiper code |
| shutdown_o | output | 1 | Shutdown flag |

## Verification
The bench builds the block with STORE_CYCLES set to 6000. At that setting one store outlasts about five bus transactions. A second store can therefore be issued while the first is still in progress, and the saved location can be read back before either store finishes. TOL_BYTE is set to 0x5A so the tolerance read cannot be mistaken for the saved wiper. INIT_WIPER stays at 0x40, which makes the wiper value loaded at reset distinct from every code the bench writes. DEV_ADDR keeps its default, so the bench can use the alternate address 0101100 as a non-matching target.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_STORE    = 3'd1,
    OP_SET      = 3'd2,
    OP_SHDN     = 3'd3,
    OP_RESTORE  = 3'd4,
    OP_SEL_WIP  = 3'd5,
    OP_SEL_NV   = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    B_IDLE,
    B_RX,
    B_ACK,
    B_TX,
    B_RACK
  } bus_st_e;

  function automatic logic addr_hit(input logic [7:0] first_byte, input logic [6:0] own);
    return first_byte[7:1] == own;
  endfunction

  function automatic logic is_read(input logic [7:0] first_byte);
    return first_byte[0];
  endfunction

endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], line_i};
  end

  assign lvl_o  = sh[STAGES-2];
  assign rise_o = sh[STAGES-2] & ~sh[STAGES-1];
  assign fall_o = ~sh[STAGES-2] & sh[STAGES-1];
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
  import dpot_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0101111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_lvl,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_lvl,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic [7:0] rd_byte_i,
  output logic       sda_pull_o,
  output logic       word_valid_o,
  output logic [2:0] word_cmd_o,
  output logic [7:0] word_data_o,
  output logic       idle_o
);
  bus_st_e    st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic [7:0] tx_sh;
  logic       in_addr;
  logic       rd_dir;
  logic       hi_next;
  logic       fire_pend;
  logic       pull_q;
  logic       start_det;
  logic       stop_det;

  assign start_det = scl_lvl & ~scl_rise & sda_fall;
  assign stop_det  = scl_lvl & ~scl_rise & sda_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= B_IDLE;
      cnt          <= '0;
      shreg        <= '0;
      tx_sh        <= '0;
      in_addr      <= 1'b0;
      rd_dir       <= 1'b0;
      hi_next      <= 1'b1;
      fire_pend    <= 1'b0;
      pull_q       <= 1'b0;
      word_valid_o <= 1'b0;
      word_cmd_o   <= '0;
      word_data_o  <= '0;
    end else begin
      word_valid_o <= 1'b0;
      if (start_det) begin
        st        <= B_RX;
        cnt       <= '0;
        in_addr   <= 1'b1;
        hi_next   <= 1'b1;
        fire_pend <= 1'b0;
        pull_q    <= 1'b0;
      end else if (stop_det) begin
        st        <= B_IDLE;
        fire_pend <= 1'b0;
        pull_q    <= 1'b0;
      end else begin
        unique case (st)
          B_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_lvl};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (in_addr) begin
                if (addr_hit(shreg, DEV_ADDR)) begin
                  st     <= B_ACK;
                  pull_q <= 1'b1;
                  rd_dir <= is_read(shreg);
                end else begin
                  st <= B_IDLE;
                end
              end else begin
                st     <= B_ACK;
                pull_q <= 1'b1;
                if (hi_next) word_cmd_o <= shreg[2:0];
                else         word_data_o <= shreg;
                fire_pend <= ~hi_next;
              end
            end
          end
          B_ACK: begin
            if (scl_fall) begin
              cnt     <= '0;
              in_addr <= 1'b0;
              if (in_addr && rd_dir) begin
                st     <= B_TX;
                tx_sh  <= rd_byte_i;
                pull_q <= ~rd_byte_i[7];
              end else begin
                st     <= B_RX;
                pull_q <= 1'b0;
              end
              if (!in_addr) begin
                hi_next      <= ~hi_next;
                word_valid_o <= fire_pend;
                fire_pend    <= 1'b0;
              end
            end
          end
          B_TX: begin
            if (scl_fall) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                st     <= B_RACK;
                pull_q <= 1'b0;
              end else begin
                tx_sh  <= tx_sh << 1;
                pull_q <= ~tx_sh[6];
              end
            end
          end
          B_RACK: begin
            if (scl_fall) st <= B_IDLE;
          end
          default: st <= B_IDLE;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign idle_o     = (st == B_IDLE);
endmodule

// File: rtl/dpot_state.sv
module dpot_state
  import dpot_pkg::*;
#(
  parameter int          WIPER_W      = 7,
  parameter int          STORE_CYCLES = 500,
  parameter logic [6:0]  INIT_WIPER   = 7'h40,
  parameter logic [7:0]  TOL_BYTE     = 8'h64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_valid_i,
  input  logic [2:0]         word_cmd_i,
  input  logic [7:0]         word_data_i,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               shutdown_o,
  output logic [7:0]         rd_byte_o,
  output logic               boot_o,
  output logic               busy_o,
  output logic               queued_o
);
  localparam int NV_IDX_W = 2;
  localparam int NV_DEPTH = 1 << NV_IDX_W;
  localparam int CNT_W    = $clog2(STORE_CYCLES + 1);

  logic [7:0]          saved;
  logic [7:0]          nv_loc [NV_DEPTH];
  logic [WIPER_W-1:0]  st_val;
  logic [CNT_W-1:0]    busy_cnt;
  logic                boot_q;
  logic                rd_nv;
  logic [NV_IDX_W-1:0] rd_idx;
  logic                store_req;
  op_e                 op;

  assign op        = op_e'(word_cmd_i);
  assign store_req = word_valid_i && (op == OP_STORE);

  for (genvar i = 0; i < NV_DEPTH; i++) begin : g_nv
    if (i == 0)      begin : g_saved assign nv_loc[i] = saved;    end
    else if (i == 1) begin : g_tol   assign nv_loc[i] = TOL_BYTE; end
    else             begin : g_zero  assign nv_loc[i] = 8'h00;    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q     <= 1'b1;
      wiper_o    <= '0;
      shutdown_o <= 1'b0;
      rd_nv      <= 1'b0;
      rd_idx     <= '0;
    end else begin
      boot_q <= 1'b0;
      if (boot_q) begin
        wiper_o <= saved[WIPER_W-1:0];
      end else if (word_valid_i) begin
        unique case (op)
          OP_SET:     wiper_o    <= word_data_i[WIPER_W-1:0];
          OP_SHDN:    shutdown_o <= word_data_i[0];
          OP_RESTORE: wiper_o    <= saved[WIPER_W-1:0];
          OP_SEL_WIP: rd_nv      <= 1'b0;
          OP_SEL_NV: begin
            rd_nv  <= 1'b1;
            rd_idx <= word_data_i[NV_IDX_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved    <= 8'(INIT_WIPER);
      st_val   <= '0;
      busy_cnt <= '0;
      queued_o <= 1'b0;
    end else if (busy_cnt == '0) begin
      if (store_req) begin
        busy_cnt <= CNT_W'(STORE_CYCLES);
        st_val   <= wiper_o;
      end
    end else if (busy_cnt == CNT_W'(1)) begin
      saved <= 8'(st_val);
      if (queued_o || store_req) begin
        busy_cnt <= CNT_W'(STORE_CYCLES);
        st_val   <= wiper_o;
        queued_o <= 1'b0;
      end else begin
        busy_cnt <= '0;
      end
    end else begin
      busy_cnt <= busy_cnt - CNT_W'(1);
      if (store_req) queued_o <= 1'b1;
    end
  end

  assign rd_byte_o = rd_nv ? nv_loc[rd_idx] : 8'(wiper_o);
  assign boot_o    = boot_q;
  assign busy_o    = (busy_cnt != '0);
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl #(
  parameter logic [6:0] DEV_ADDR     = 7'b0101111,
  parameter int         WIPER_W      = 7,
  parameter int         STORE_CYCLES = 500,
  parameter logic [6:0] INIT_WIPER   = 7'h40,
  parameter logic [7:0] TOL_BYTE     = 8'h64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  output logic [WIPER_W-1:0] wiper_o,
  output logic               shutdown_o
);
  logic       scl_lvl, scl_rise, scl_fall;
  logic       sda_lvl, sda_rise, sda_fall;
  logic       word_valid;
  logic [2:0] word_cmd;
  logic [7:0] word_data;
  logic [7:0] rd_byte;
  logic       boot_phase;
  logic       store_busy;
  logic       store_pend;
  logic       slv_idle;

  dpot_line_sync #(.STAGES(3)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  dpot_line_sync #(.STAGES(3)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  dpot_i2c_target #(.DEV_ADDR(DEV_ADDR)) u_target (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .rd_byte_i(rd_byte), .sda_pull_o(sda_pull_o),
    .word_valid_o(word_valid), .word_cmd_o(word_cmd), .word_data_o(word_data),
    .idle_o(slv_idle)
  );

  dpot_state #(
    .WIPER_W(WIPER_W), .STORE_CYCLES(STORE_CYCLES),
    .INIT_WIPER(INIT_WIPER), .TOL_BYTE(TOL_BYTE)
  ) u_state (
    .clk(clk), .rst_n(rst_n),
    .word_valid_i(word_valid), .word_cmd_i(word_cmd), .word_data_i(word_data),
    .wiper_o(wiper_o), .shutdown_o(shutdown_o), .rd_byte_o(rd_byte),
    .boot_o(boot_phase), .busy_o(store_busy), .queued_o(store_pend)
  );
endmodule

// File: rtl/dpot_chk.sv
module dpot_chk #(
  parameter int W = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         word_valid,
  input logic [2:0]   word_cmd,
  input logic [7:0]   word_data,
  input logic         boot_phase,
  input logic [W-1:0] wiper,
  input logic         shutdown,
  input logic         store_busy,
  input logic         slv_idle,
  input logic         sda_pull
);
  // R3: a set command lands its operand in the wiper on the next cycle
  p_set_wiper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_cmd == 3'd2) |=> (wiper == $past(word_data[W-1:0])));

  // R3: without a completed word the wiper holds its value
  p_hold_wiper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_valid && !boot_phase) |=> $stable(wiper));

  // R5: shutdown follows operand bit 0
  p_shutdown_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_cmd == 3'd3) |=> (shutdown == $past(word_data[0])));

  // R10: codes 0 and 7 touch neither output
  p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && (word_cmd == 3'd0 || word_cmd == 3'd7)) |=> ($stable(wiper) && $stable(shutdown)));

  // R11: a store arriving while busy keeps the store engine busy
  p_queue_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_cmd == 3'd1 && store_busy) |=> store_busy);

  // R9: an idle target never pulls SDA
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slv_idle |-> !sda_pull);
endmodule

bind dpot_i2c_ctrl dpot_chk #(.W(WIPER_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .word_valid(word_valid), .word_cmd(word_cmd), .word_data(word_data),
  .boot_phase(boot_phase), .wiper(wiper_o), .shutdown(shutdown_o),
  .store_busy(store_busy), .slv_idle(slv_idle), .sda_pull(sda_pull_o)
);

// File: tb/dpot_i2c_ctrl_bench.sv
module dpot_i2c_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 10;
  localparam logic [6:0] OWN_ADDR   = 7'b0101111;
  localparam logic [6:0] OTHER_ADDR = 7'b0101100;
  localparam logic [7:0] TOL        = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_bus;
  logic [6:0] wiper;
  logic shutdown;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_pull;

  dpot_i2c_ctrl #(
    .DEV_ADDR(OWN_ADDR), .WIPER_W(7), .STORE_CYCLES(6000),
    .INIT_WIPER(7'h40), .TOL_BYTE(TOL)
  ) u_dpot_i2c_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .wiper_o(wiper), .shutdown_o(shutdown)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic write_word(input logic [6:0] a, input logic [2:0] cmd,
                            input logic [7:0] data, output logic [2:0] acks);
    logic k;
    bus_start();
    put_byte({a, 1'b0}, k); acks[2] = k;
    if (k) begin
      put_byte({5'b0, cmd}, k); acks[1] = k;
      put_byte(data, k);        acks[0] = k;
    end else acks[1:0] = 2'b00;
    bus_stop();
    tick(5);
  endtask

  task automatic cmd_word(input logic [2:0] cmd, input logic [7:0] data);
    logic [2:0] acks;
    write_word(OWN_ADDR, cmd, data, acks);
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    logic       k, b;
    logic [7:0] v;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_start();
    put_byte({OWN_ADDR, 1'b1}, k);
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1);
    bus_stop();
    obs_q.push_back(v);
    tick(5);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(o), int'(e));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    logic [2:0] acks;
    logic k;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R9: reset state
    check("R9 wiper", int'(wiper), 'h40);
    check("R9 shutdown", int'(shutdown), 0);
    check("R9 sda", int'(sda_pull), 0);

    // R1: other address ignored
    write_word(OTHER_ADDR, 3'd2, 8'h11, acks);
    check("R1 addr nack", int'(acks[2]), 0);
    check("R1 wiper kept", int'(wiper), 'h40);

    // R2 / R3: full write acknowledged, wiper loaded
    write_word(OWN_ADDR, 3'd2, 8'h25, acks);
    check("R2 acks", int'(acks), 'b111);
    check("R3 wiper", int'(wiper), 'h25);

    // R4: partial word then stop
    bus_start();
    put_byte({OWN_ADDR, 1'b0}, k);
    put_byte(8'h02, k);
    bus_stop();
    tick(5);
    check("R4 partial stop", int'(wiper), 'h25);
    // R4: partial word then repeated start into a no-op word
    bus_start();
    put_byte({OWN_ADDR, 1'b0}, k);
    put_byte(8'h02, k);
    cmd_word(3'd0, 8'h00);
    check("R4 partial restart", int'(wiper), 'h25);

    // R5: shutdown on, off, bit 0 only
    cmd_word(3'd3, 8'h01);
    check("R5 on", int'(shutdown), 1);
    cmd_word(3'd3, 8'hFE);
    check("R5 upper bits ignored", int'(shutdown), 0);

    // R10: codes 0 and 7
    cmd_word(3'd0, 8'h7F);
    check("R10 nop wiper", int'(wiper), 'h25);
    cmd_word(3'd7, 8'h01);
    check("R10 code7 wiper", int'(wiper), 'h25);
    check("R10 code7 shutdown", int'(shutdown), 0);

    // R7: wiper read-back
    cmd_word(3'd5, 8'h00);
    read_expect(8'h25, "R7 wiper read");
    cmd_word(3'd2, 8'h80);
    check("R3 bit7 dropped", int'(wiper), 0);
    read_expect(8'h00, "R7 wiper read zero");

    // R8: persistent read-back
    cmd_word(3'd6, 8'h01);
    read_expect(TOL, "R8 tolerance");
    cmd_word(3'd6, 8'h00);
    read_expect(8'h40, "R8 saved wiper");

    // R11 / R6: store, queued store, delayed visibility, restore
    cmd_word(3'd2, 8'h11);
    cmd_word(3'd1, 8'h00);
    cmd_word(3'd2, 8'h22);
    cmd_word(3'd1, 8'h00);
    cmd_word(3'd6, 8'h00);
    read_expect(8'h40, "R11 saved before completion");
    tick(14000);
    read_expect(8'h22, "R11 queued store result");
    cmd_word(3'd2, 8'h33);
    check("R6 wiper before restore", int'(wiper), 'h33);
    cmd_word(3'd4, 8'h00);
    check("R6 restore", int'(wiper), 'h22);

    tick(20);
    finish_run();
  end
endmodule